// File: doc/BRIEF.md
# Flow-through burst SRAM core

This block is a single-port synchronous static memory that registers its address, control and write data on the rising clock edge but has no register on the read path. The word addressed by the registered state is driven onto the read-data port in the same cycle, after the array access delay. A starting address is captured by either of two active-low strobes. One strobe is meant for a processor and the other for a cache controller. After the capture, a 2-bit counter walks the two low address bits through a four-beat burst.

The burst order is set by a mode pin. With the pin low, the low bits count upward and wrap modulo four. With the pin high, the low bits are the starting bits XORed with the beat count. Writes are byte-lane writes. A global write stores every lane. Otherwise a byte-write enable together with per-lane selects picks the lanes to store. The write itself is committed on the edge that closes the write cycle. Output enable acts asynchronously. A registered chip deselect turns the read driver off in the very next cycle. The array depth and the lane count and width are parameters.

Top module: `fts_burst_sram`

## Requirements
- R1: When a strobe loads an address, the word at that address appears on `dq_out` with `dq_oe` high in the cycle right after that edge. No extra register stage is added.
- R2: In cycles with no load, the burst position moves to the next beat only on edges where `adv_n` is low. With `adv_n` high, the same word stays on `dq_out`.
- R3: With `ilv_mode`=0 the low two address bits follow start, start+1, start+2, start+3 modulo 4, and then wrap back to start. The upper address bits never change during a burst.
- R4: With `ilv_mode`=1 the low two address bits follow start XOR 0, 1, 2, 3 in that order.
- R5: A load on an edge where `adv_n` is also low restarts the burst at the new address at beat 0. The advance is ignored.
- R6: On a write cycle with `gw_n` low, all lanes are written, whatever the values of `bwe_n` and `bw_n`.
- R7: When `gw_n` is high and `bwe_n` is low, only lanes whose `bw_n` bit is 0 are written. Lane i is `din`/`dq_out` bits [9i+8:9i]. When `bwe_n` is also high, the cycle is a read.
- R8: `ads_proc_n` has no effect while `ce_n` is high, and the burst continues. A strobe seen while the chip is not enabled deselects the chip. The chip is enabled when `ce_n`=0, `cs_hi`=1 and `cs_lo_n`=0.
- R9: A load made by `ads_proc_n` is always a read. The write controls are ignored in that cycle.
- R10: After a deselect edge, `dq_oe` is low from the next cycle on. It stays low, and no write is done, until the next load. That load turns the driver back on in the cycle after its edge.
- R11: `oe_n` high forces `dq_oe` low and `dq_out` to zero without waiting for a clock. `dq_oe` is also low during write cycles.
- R12: During and right after reset the driver is off (`dq_oe`=0, `dq_out`=0) and no write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Word address, captured on a load |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_ctrl_n | input | 1 | Cache-controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ilv_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| ce_n | input | 1 | Chip enable, active low, sampled on the clock |
| cs_hi | input | 1 | Chip select, active high, sampled on the clock |
| cs_lo_n | input | 1 | Chip select, active low, sampled on the clock |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data, zero when not driven |
| dq_oe | output | 1 | Read driver enable for the pad |

## Verification
Two things can land on the same edge: a new address load and a burst advance. The bench provokes this by pulsing the processor strobe with `adv_n` held low in the middle of a burst. It then judges that the new start word appears and that the next beat follows the new start. A second collision is a write commit and a read of the same word on the following edge. The bench places an ADSC write directly before a processor-strobe read of the same address. It expects the freshly written word, including the partially merged lanes, with no idle cycle between the two.

// File: rtl/fts_pkg.sv
package fts_pkg;

  // Decoded event of one clock edge.
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_LOAD_P = 2'd1,
    EV_LOAD_C = 2'd2,
    EV_DESEL  = 2'd3
  } fts_ev_e;

  // Low address bits for a burst beat.
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    burst_lo = ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_n,
  input  logic                    cs_hi,
  input  logic                    cs_lo_n,
  input  logic                    ads_proc_n,
  input  logic                    ads_ctrl_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic                    load_o,
  output logic                    step_o,
  output logic                    active_o,
  output logic                    wr_o,
  output logic [LANES-1:0]        wmask_o,
  output logic [LANES*LANE_W-1:0] wdata_o
);

  localparam int DW = LANES * LANE_W;

  fts_ev_e          ev;
  logic             chip_en;
  logic             p_strobe;
  logic             c_strobe;
  logic [LANES-1:0] req_mask;
  logic             req_wr;

  logic             active_d, active_q;
  logic             wr_d, wr_q;
  logic [LANES-1:0] wmask_d, wmask_q;
  logic [DW-1:0]    wdata_q;

  assign chip_en  = ~ce_n & cs_hi & ~cs_lo_n;
  assign p_strobe = ~ads_proc_n & ~ce_n;
  assign c_strobe = ~ads_ctrl_n;

  // Per-lane request: global write overrides the lane selects.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign req_mask[g] = ~gw_n | (~bwe_n & ~bw_n[g]);
  end
  assign req_wr = |req_mask;

  always_comb begin
    ev = EV_NONE;
    if (p_strobe)      ev = chip_en ? EV_LOAD_P : EV_DESEL;
    else if (c_strobe) ev = chip_en ? EV_LOAD_C : EV_DESEL;
  end

  always_comb begin
    active_d = active_q;
    wr_d     = 1'b0;
    unique case (ev)
      EV_LOAD_P: begin active_d = 1'b1; wr_d = 1'b0;   end
      EV_LOAD_C: begin active_d = 1'b1; wr_d = req_wr; end
      EV_DESEL:  begin active_d = 1'b0; wr_d = 1'b0;   end
      default:   begin active_d = active_q; wr_d = active_q & req_wr; end
    endcase
    wmask_d = wr_d ? req_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      wmask_q  <= '0;
    end else begin
      active_q <= active_d;
      wr_q     <= wr_d;
      wmask_q  <= wmask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_d) wdata_q <= din;
  end

  assign load_o   = (ev == EV_LOAD_P) || (ev == EV_LOAD_C);
  assign step_o   = (ev == EV_NONE) & active_q & ~adv_n;
  assign active_o = active_q;
  assign wr_o     = wr_q;
  assign wmask_o  = wmask_q;
  assign wdata_o  = wdata_q;

  // R9: processor-strobe load never becomes a write
  p_pload_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_proc_n && !ce_n) |=> !wr_q);

  // R7: lane selects pick exactly the written lanes
  p_lane_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_ctrl_n && chip_en && gw_n && !bwe_n && ads_proc_n && (bw_n != '1))
      |=> wmask_q == ~$past(bw_n));

endmodule

// File: rtl/fts_burst_ctr.sv
module fts_burst_ctr
  import fts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       step,
  input  logic [1:0] start_lo,
  input  logic       ilv_mode,
  output logic [1:0] lo
);

  logic [1:0] base_d, base_q;
  logic [1:0] cnt_d, cnt_q;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = start_lo;
      cnt_d  = 2'd0;
    end else if (step) begin
      cnt_d  = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= 2'd0;
      cnt_q  <= 2'd0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign lo = burst_lo(base_q, cnt_q, ilv_mode);

  // R5: a load restarts at the presented low bits
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == 2'd0) && (base_q == $past(start_lo)));

  // R2: no step, no movement
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cnt_q) && $stable(base_q));

  // R4: interleaved beat differs from the previous one by the count's toggled bits
  p_ilv_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ilv_mode) |=>
      (!ilv_mode || lo == ($past(lo) ^ ($past(cnt_q) ^ ($past(cnt_q) + 2'd1)))));

endmodule

// File: rtl/fts_array.sv
module fts_array #(
  parameter int WORDS  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic [$clog2(WORDS)-1:0]  addr,
  input  logic [LANES-1:0]          we,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata
);

  // One storage column per lane so each lane has a single writer.
  for (genvar g = 0; g < LANES; g++) begin : g_col
    logic [LANE_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[addr];
  end

endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ads_proc_n,
  input  logic                    ads_ctrl_n,
  input  logic                    adv_n,
  input  logic                    ilv_mode,
  input  logic                    ce_n,
  input  logic                    cs_hi,
  input  logic                    cs_lo_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int DW    = LANES * LANE_W;
  localparam int WORDS = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 2;

  // Reset: asserted at once, released after two clean edges.
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic             load, step, active, wr;
  logic [LANES-1:0] wmask;
  logic [DW-1:0]    wdata, rdata;
  logic [1:0]       lo;
  logic [HI_W-1:0]  hi_d, hi_q;
  logic [ADDR_W-1:0] cur_addr;
  logic             chip_on;

  fts_ctrl #(.LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i),
    .ce_n       (ce_n),
    .cs_hi      (cs_hi),
    .cs_lo_n    (cs_lo_n),
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .adv_n      (adv_n),
    .gw_n       (gw_n),
    .bwe_n      (bwe_n),
    .bw_n       (bw_n),
    .din        (din),
    .load_o     (load),
    .step_o     (step),
    .active_o   (active),
    .wr_o       (wr),
    .wmask_o    (wmask),
    .wdata_o    (wdata)
  );

  fts_burst_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_i),
    .load     (load),
    .step     (step),
    .start_lo (addr[1:0]),
    .ilv_mode (ilv_mode),
    .lo       (lo)
  );

  assign hi_d = load ? addr[ADDR_W-1:2] : hi_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  assign cur_addr = {hi_q, lo};

  fts_array #(.WORDS(WORDS), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .addr  (cur_addr),
    .we    (wmask),
    .wdata (wdata),
    .rdata (rdata)
  );

  // Flow-through read path: no register after the array.
  assign dq_oe  = ~oe_n & active & ~wr;
  assign dq_out = dq_oe ? rdata : '0;

  assign chip_on = ~ce_n & cs_hi & ~cs_lo_n;

  // R1: a load presents exactly the captured address
  p_load_addr_r1: assert property (@(posedge clk) disable iff (!rst_i)
    load |=> cur_addr == $past(addr));

  // R3: linear step increments low bits, upper bits kept
  p_lin_step_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (step && !load && !ilv_mode) |=>
      (ilv_mode || (lo == $past(lo) + 2'd1 && hi_q == $past(hi_q))));

  // R6: global write selects every lane
  p_gw_all_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (!gw_n && !ads_ctrl_n && ads_proc_n && chip_on) |=> wmask == '1);

  // R8: processor strobe with chip enable high does not load
  p_ce_ignore_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (!ads_proc_n && ce_n && ads_ctrl_n) |-> !load);

  // R10: a deselecting strobe silences the driver next cycle
  p_desel_off_r10: assert property (@(posedge clk) disable iff (!rst_i)
    (!ads_ctrl_n && !chip_on && (ads_proc_n || ce_n)) |=> !dq_oe);

endmodule

// File: tb/fts_burst_sram_tb.sv
module fts_burst_sram_tb;

  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  // {ilv, start[1:0], beat0, beat1, beat2, beat3}
  localparam logic [10:0] BT [8] = '{
    {1'b0, 2'd0, 8'b00_01_10_11},
    {1'b0, 2'd1, 8'b01_10_11_00},
    {1'b0, 2'd2, 8'b10_11_00_01},
    {1'b0, 2'd3, 8'b11_00_01_10},
    {1'b1, 2'd0, 8'b00_01_10_11},
    {1'b1, 2'd1, 8'b01_00_11_10},
    {1'b1, 2'd2, 8'b10_11_00_01},
    {1'b1, 2'd3, 8'b11_10_01_00}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ads_proc_n, ads_ctrl_n, adv_n, ilv_mode;
  logic          ce_n, cs_hi, cs_lo_n, gw_n, bwe_n, oe_n;
  logic [LN-1:0] bw_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int n_chk = 0;
  int n_fail = 0;

  fts_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ads_proc_n(ads_proc_n),
    .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .ilv_mode(ilv_mode), .ce_n(ce_n),
    .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .oe_n(oe_n), .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {4{3'b101, a}};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ads_proc_n = 1'b1; ads_ctrl_n = 1'b1; adv_n = 1'b1;
    ce_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; oe_n = 1'b0;
    din = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr_full(input logic [AW-1:0] a, input logic [DW-1:0] d);
    idle(); ads_ctrl_n = 1'b0; gw_n = 1'b0; addr = a; din = d;
    tick();
  endtask

  task automatic rd_load(input logic [AW-1:0] a);
    idle(); ads_proc_n = 1'b0; addr = a;
    tick();
  endtask

  task automatic advance();
    idle(); adv_n = 1'b0;
    tick();
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle();
    ilv_mode = 1'b0;
    addr = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R12 oe in reset", {35'b0, dq_oe}, '0);
    chk("R12 data in reset", dq_out, '0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R12 oe after reset", {35'b0, dq_oe}, '0);

    // Preload the burst block 8..11
    for (int a = 8; a < 12; a++) begin
      wr_full(AW'(a), pat(AW'(a)));
      chk("R11 driver off in write cycle", {35'b0, dq_oe}, '0);
    end

    // Vector table: burst order in both modes
    for (int i = 0; i < 8; i++) begin
      automatic logic [1:0] st = BT[i][9:8];
      automatic logic [7:0] sq = BT[i][7:0];
      ilv_mode = BT[i][10];
      rd_load({4'd2, st});
      chk("R1 load word", dq_out, pat({4'd2, sq[7:6]}));
      chk("R1 driver on", {35'b0, dq_oe}, 36'd1);
      for (int b = 1; b < 4; b++) begin
        advance();
        chk(BT[i][10] ? "R4 interleaved beat" : "R3 linear beat",
            dq_out, pat({4'd2, sq[7-2*b -: 2]}));
      end
      advance();
      chk("R3 wrap to start", dq_out, pat({4'd2, sq[7:6]}));
    end
    ilv_mode = 1'b0;

    // R2: hold without advance
    rd_load(6'd9);
    idle(); tick();
    chk("R2 hold", dq_out, pat(6'd9));
    advance();
    chk("R2 advance", dq_out, pat(6'd10));

    // R5: load wins over advance
    idle(); ads_proc_n = 1'b0; adv_n = 1'b0; addr = 6'd11; tick();
    chk("R5 restart word", dq_out, pat(6'd11));
    advance();
    chk("R5 next after restart", dq_out, pat(6'd8));

    // R8: processor strobe ignored when ce_n high
    rd_load(6'd8);
    idle(); ads_proc_n = 1'b0; ce_n = 1'b1; adv_n = 1'b0; addr = 6'd30; tick();
    chk("R8 strobe ignored", dq_out, pat(6'd9));
    // R8 / R10: deselect via controller strobe with select inactive
    idle(); ads_ctrl_n = 1'b0; cs_hi = 1'b0; gw_n = 1'b0; tick();
    chk("R8 deselect", {35'b0, dq_oe}, '0);
    idle(); gw_n = 1'b0; tick();
    chk("R10 stays off", {35'b0, dq_oe}, '0);
    rd_load(6'd9);
    chk("R10 reenable", {35'b0, dq_oe}, 36'd1);
    chk("R10 no write while off", dq_out, pat(6'd9));

    // R6: global write beats lane selects
    idle(); ads_ctrl_n = 1'b0; gw_n = 1'b0; addr = 6'd20; din = 36'h123456789; tick();
    chk("R11 off in write", {35'b0, dq_oe}, '0);
    rd_load(6'd20);
    chk("R6 all lanes", dq_out, 36'h123456789);

    // R7: lane writes, then bwe_n high is a read
    wr_full(6'd21, pat(6'd21));
    idle(); ads_ctrl_n = 1'b0; bwe_n = 1'b0; bw_n = 4'b1010; addr = 6'd21;
    din = {4{9'h0AA}}; tick();
    rd_load(6'd21);
    chk("R7 lanes 0 and 2", dq_out,
        {pat(6'd21)[35:27], 9'h0AA, pat(6'd21)[17:9], 9'h0AA});
    idle(); ads_ctrl_n = 1'b0; bwe_n = 1'b1; bw_n = '0; addr = 6'd21;
    din = '1; tick();
    chk("R7 read when bwe_n high", dq_out,
        {pat(6'd21)[35:27], 9'h0AA, pat(6'd21)[17:9], 9'h0AA});

    // R9: processor load ignores write controls
    wr_full(6'd22, pat(6'd22));
    idle(); ads_proc_n = 1'b0; gw_n = 1'b0; addr = 6'd22; din = '0; tick();
    chk("R9 read on processor load", dq_out, pat(6'd22));
    idle(); tick();
    chk("R9 word intact", dq_out, pat(6'd22));

    // R11: asynchronous output enable
    rd_load(6'd8);
    oe_n = 1'b1;
    #1;
    chk("R11 oe_n high off", {35'b0, dq_oe}, '0);
    chk("R11 data zero", dq_out, '0);
    oe_n = 1'b0;
    #1;
    chk("R11 oe_n low on", dq_out, pat(6'd8));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule